// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block turns one tagged scalar instruction into a stream of element operations. Once a vector length has been loaded and the instruction is started, it presents one element per cycle. Each element carries a source offset, a destination offset, a sub-element offset and a kind code. The kind code tells the execution unit whether to run the element, pass over it, or write zero to its destination. The outer index runs over the vector length. The inner index runs over a group of one to four sub-elements and advances first. One predicate bit governs a whole group.

The execution unit accepts each presented element with a ready signal. In the same cycle it reports whether that element raised an exception and, in fail-first mode, whether the result was zero. An exception stops the sequence and leaves the offsets where they were, so a later start resumes from that element. A normal end, or an early end in fail-first mode, returns every offset to zero and gives a one-cycle completion pulse. A loaded vector length of zero means the instruction is not vectorised, and exactly one scalar element is issued.

Top module: `els_seq`

## Requirements
- R1: After reset, el_valid and loop_done are low and src_off, dst_off and sub_off are zero.
- R2: After a start pulse in idle, elements are presented from the current offsets in increasing order, with sub_off advancing fastest. subvl_code values 0 to 3 give group sizes 1 to 4. Each accepted element moves the offsets on by one, and dst_off always equals src_off.
- R3: The effective predicate bit of element i is `(pred_zero_reg ? 0 : pred_mask[i]) XOR pred_invert`, and it applies to every sub-element of element i. el_kind is 2'b00 for run, 2'b01 for skip and 2'b10 for zero.
- R4: With zero_mode low, an element whose effective bit is 0 is presented with kind skip (2'b01), and accepting it still advances the offsets.
- R5: With zero_mode high, an element whose effective bit is 0 is presented with kind zero (2'b10).
- R6: When a non-skip element is accepted with el_exc high, el_valid falls in the next cycle, the offsets keep their values, and no loop_done pulse follows. The next start resumes at those offsets.
- R7: When the final element (element VL-1, last sub-element) is accepted, loop_done is high for exactly one cycle in the next cycle. At that point el_valid is low and all offsets are zero.
- R8: A vl_load pulse while idle stores vl_value and returns all offsets to zero, including after an exception has stopped the sequence.
- R9: With ff_enable high, accepting a run element with el_cmp_zero high ends the loop exactly as in R7, with no further elements.
- R10: With ff_enable and zero_mode both high, the first accepted zero-kind element ends the loop. With ff_enable high and zero_mode low, el_cmp_zero is ignored on skip elements.
- R11: pred_zero_reg with pred_invert high makes every element run, whatever pred_mask holds. pred_zero_reg with pred_invert low masks every element.
- R12: With a loaded vector length of 0, exactly one element is issued, at offsets zero and with kind run, regardless of mask, group size and fail-first. It is followed by loop_done.
- R13: While el_valid is high and el_ready is low, the presented element and its offsets stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_load | input | 1 | Load a new vector length (honoured when idle) |
| vl_value | input | VL_W | Vector length to load, 0 to MAXVL |
| start | input | 1 | Begin or resume the element loop (honoured when idle) |
| subvl_code | input | 2 | Group size minus one |
| pred_mask | input | MAXVL | Predicate bits, one per element |
| pred_zero_reg | input | 1 | Predicate source is the hard-wired zero register |
| pred_invert | input | 1 | Complement the predicate before use |
| zero_mode | input | 1 | Masked elements are written with zero instead of skipped |
| ff_enable | input | 1 | Fail-first early termination enabled |
| el_ready | input | 1 | Execution unit accepts the presented element |
| el_exc | input | 1 | Accepted element raised an exception |
| el_cmp_zero | input | 1 | Accepted element produced a zero result |
| el_valid | output | 1 | An element is being presented |
| src_off | output | OFF_W | Source element offset |
| dst_off | output | OFF_W | Destination element offset |
| sub_off | output | 2 | Sub-element offset within the group |
| el_kind | output | 2 | 00 run, 01 skip, 10 zero |
| loop_done | output | 1 | One-cycle pulse when the loop has finished |

## Verification
A corrupted offset counter shows up on the very next presented element as a wrong src_off or sub_off, or as dst_off parting from src_off. A wrong group-end decision shows up within one group as a missing or extra sub-element. A bad predicate path shows up as a wrong el_kind on the element it concerns. Faults in termination are seen one cycle after the deciding acceptance: a missing or doubled loop_done, a sequence that carries on past a fail-first stop, or offsets that move or clear after an exception. The scoreboard compares every accepted element and every completion pulse, in order, against a model built from the requirements, so any of these is caught at the first element where it differs.

// File: rtl/els_pkg.sv
package els_pkg;

    parameter int unsigned DEF_MAXVL = 16;

    typedef enum logic [1:0] {
        EK_RUN  = 2'b00,
        EK_SKIP = 2'b01,
        EK_ZERO = 2'b10
    } elem_kind_e;

    // Effective predicate bit plus mode to element kind.
    function automatic elem_kind_e classify(input logic eff_bit,
                                            input logic zero_mode,
                                            input logic scalar);
        if (scalar || eff_bit)
            return EK_RUN;
        else if (zero_mode)
            return EK_ZERO;
        else
            return EK_SKIP;
    endfunction

endpackage

// File: rtl/els_pred_sel.sv
module els_pred_sel #(
    parameter int unsigned MAXVL = 16,
    localparam int unsigned OFF_W = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic [MAXVL-1:0]        mask,
    input  logic                    use_zero_reg,
    input  logic                    invert,
    input  logic                    zero_mode,
    input  logic                    scalar,
    input  logic [OFF_W-1:0]        elem,
    output els_pkg::elem_kind_e     kind
);
    logic raw_bit;
    logic eff_bit;

    // The zero register reads as all zeros; the invert acts after that.
    assign raw_bit = use_zero_reg ? 1'b0 : mask[elem];
    assign eff_bit = raw_bit ^ invert;
    assign kind    = els_pkg::classify(eff_bit, zero_mode, scalar);
endmodule

// File: rtl/els_offset_ctr.sv
module els_offset_ctr #(
    parameter int unsigned OFF_W = 4,
    parameter int unsigned LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        advance,
    input  logic [1:0]                  sub_lim,
    output logic [LANES-1:0][OFF_W-1:0] elem_q,
    output logic [1:0]                  sub_q,
    output logic                        group_end
);
    assign group_end = (sub_q == sub_lim);

    always_ff @(posedge clk) begin
        if (rst || clear)
            sub_q <= 2'd0;
        else if (advance)
            sub_q <= group_end ? 2'd0 : sub_q + 2'd1;
    end

    // One element counter per lane (source, destination).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OFF_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst || clear)
                cnt_q <= '0;
            else if (advance && group_end)
                cnt_q <= cnt_q + OFF_W'(1);
        end
        assign elem_q[g] = cnt_q;
    end
endmodule

// File: rtl/els_seq.sv
module els_seq #(
    parameter int unsigned MAXVL = els_pkg::DEF_MAXVL,
    localparam int unsigned VL_W  = $clog2(MAXVL + 1),
    localparam int unsigned OFF_W = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vl_load,
    input  logic [VL_W-1:0]   vl_value,
    input  logic              start,
    input  logic [1:0]        subvl_code,
    input  logic [MAXVL-1:0]  pred_mask,
    input  logic              pred_zero_reg,
    input  logic              pred_invert,
    input  logic              zero_mode,
    input  logic              ff_enable,
    input  logic              el_ready,
    input  logic              el_exc,
    input  logic              el_cmp_zero,
    output logic              el_valid,
    output logic [OFF_W-1:0]  src_off,
    output logic [OFF_W-1:0]  dst_off,
    output logic [1:0]        sub_off,
    output logic [1:0]        el_kind,
    output logic              loop_done
);
    import els_pkg::*;

    localparam int unsigned LANES = 2;

    logic [VL_W-1:0]             vl_q;
    logic                        busy_q;
    logic                        done_q;
    logic                        scalar;
    logic [1:0]                  sub_lim;
    logic [LANES-1:0][OFF_W-1:0] elem_q;
    logic                        group_end;
    logic                        at_end;
    elem_kind_e                  kind;
    logic                        accept;
    logic                        halt_exc;
    logic                        ff_stop;
    logic                        finish;
    logic                        advance;
    logic                        clear;

    assign scalar  = (vl_q == '0);
    assign sub_lim = scalar ? 2'd0 : subvl_code;

    els_pred_sel #(.MAXVL(MAXVL)) u_pred (
        .mask         (pred_mask),
        .use_zero_reg (pred_zero_reg),
        .invert       (pred_invert),
        .zero_mode    (zero_mode),
        .scalar       (scalar),
        .elem         (elem_q[0]),
        .kind         (kind)
    );

    els_offset_ctr #(.OFF_W(OFF_W), .LANES(LANES)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .advance   (advance),
        .sub_lim   (sub_lim),
        .elem_q    (elem_q),
        .sub_q     (sub_off),
        .group_end (group_end)
    );

    assign at_end   = scalar || ((VL_W'(elem_q[0]) == vl_q - VL_W'(1)) && group_end);
    assign accept   = busy_q && el_ready;
    assign halt_exc = accept && el_exc && (kind != EK_SKIP);
    assign ff_stop  = ff_enable && !scalar &&
                      (((kind == EK_RUN) && el_cmp_zero) || (kind == EK_ZERO));
    assign finish   = accept && !halt_exc && (at_end || ff_stop);
    assign advance  = accept && !halt_exc && !finish;
    assign clear    = finish || (vl_load && !busy_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (!busy_q && vl_load)
                vl_q <= vl_value;
            if (!busy_q && start)
                busy_q <= 1'b1;
            else if (halt_exc || finish)
                busy_q <= 1'b0;
        end
    end

    assign el_valid  = busy_q;
    assign src_off   = elem_q[0];
    assign dst_off   = elem_q[1];
    assign el_kind   = kind;
    assign loop_done = done_q;
endmodule

// File: rtl/els_seq_chk.sv
module els_seq_chk #(
    parameter int unsigned MAXVL = 16,
    localparam int unsigned OFF_W = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       subvl_code,
    input logic             pred_zero_reg,
    input logic             pred_invert,
    input logic             el_ready,
    input logic             el_exc,
    input logic             el_valid,
    input logic [OFF_W-1:0] src_off,
    input logic [OFF_W-1:0] dst_off,
    input logic [1:0]       sub_off,
    input logic [1:0]       el_kind,
    input logic             loop_done
);
    p_twin_offsets_r2: assert property (@(posedge clk) disable iff (rst)
        src_off == dst_off);

    p_sub_bound_r2: assert property (@(posedge clk) disable iff (rst)
        el_valid |-> (sub_off <= subvl_code));

    p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
        el_valid |-> (el_kind != 2'b11));

    p_exc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (el_valid && el_ready && el_exc && (el_kind != 2'b01)) |=>
        (!el_valid && !loop_done && $stable(src_off) && $stable(sub_off)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        loop_done |=> !loop_done);

    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        loop_done |-> (!el_valid && src_off == '0 && dst_off == '0 && sub_off == 2'd0));

    p_zero_reg_inv_r11: assert property (@(posedge clk) disable iff (rst)
        (el_valid && pred_zero_reg && pred_invert) |-> (el_kind == 2'b00));

    p_stall_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (el_valid && !el_ready) |=>
        (el_valid && $stable(src_off) && $stable(sub_off) && $stable(el_kind)));
endmodule

bind els_seq els_seq_chk #(.MAXVL(MAXVL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .subvl_code    (subvl_code),
    .pred_zero_reg (pred_zero_reg),
    .pred_invert   (pred_invert),
    .el_ready      (el_ready),
    .el_exc        (el_exc),
    .el_valid      (el_valid),
    .src_off       (src_off),
    .dst_off       (dst_off),
    .sub_off       (sub_off),
    .el_kind       (el_kind),
    .loop_done     (loop_done)
);

// File: tb/els_seq_test.sv
module els_seq_test;
    localparam int MAXVL = 16;
    localparam int VL_W  = $clog2(MAXVL + 1);
    localparam int OFF_W = $clog2(MAXVL);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             vl_load = 1'b0;
    logic [VL_W-1:0]  vl_value = '0;
    logic             start = 1'b0;
    logic [1:0]       subvl_code = 2'd0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic             pred_zero_reg = 1'b0;
    logic             pred_invert = 1'b0;
    logic             zero_mode = 1'b0;
    logic             ff_enable = 1'b0;
    logic             el_ready = 1'b1;
    logic             el_exc = 1'b0;
    logic             el_cmp_zero = 1'b0;
    logic             el_valid;
    logic [OFF_W-1:0] src_off;
    logic [OFF_W-1:0] dst_off;
    logic [1:0]       sub_off;
    logic [1:0]       el_kind;
    logic             loop_done;

    els_seq #(.MAXVL(MAXVL)) uut (
        .clk(clk), .rst(rst), .vl_load(vl_load), .vl_value(vl_value), .start(start),
        .subvl_code(subvl_code), .pred_mask(pred_mask), .pred_zero_reg(pred_zero_reg),
        .pred_invert(pred_invert), .zero_mode(zero_mode), .ff_enable(ff_enable),
        .el_ready(el_ready), .el_exc(el_exc), .el_cmp_zero(el_cmp_zero),
        .el_valid(el_valid), .src_off(src_off), .dst_off(dst_off), .sub_off(sub_off),
        .el_kind(el_kind), .loop_done(loop_done)
    );

    typedef struct {
        int    src;
        int    sub;
        int    kind;
        bit    done;
        bit    exc;
        bit    cmpz;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int cur_vl = 0;
    int cur_e = 0;
    int cur_s = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops the expected stream as the design presents it.
    always @(negedge clk) begin
        exp_t it;
        if (!rst) begin
            if (loop_done) begin
                if (q.size() == 0)
                    chk(0, "R7 unexpected loop_done", 1, 0);
                else begin
                    it = q.pop_front();
                    chk(it.done, {it.tag, " loop_done position"}, 1, int'(it.done));
                    chk(!el_valid && src_off == 0 && sub_off == 0,
                        {it.tag, " R7 offsets at done"}, int'(src_off), 0);
                end
                el_exc = 1'b0;
            end else if (el_valid && el_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R2 extra element src", int'(src_off), -1);
                    el_exc = 1'b0;
                end else begin
                    it = q.pop_front();
                    chk(!it.done, {it.tag, " element instead of done"}, int'(src_off), -1);
                    chk(int'(src_off) == it.src, {it.tag, " src_off"}, int'(src_off), it.src);
                    chk(int'(sub_off) == it.sub, {it.tag, " sub_off"}, int'(sub_off), it.sub);
                    chk(int'(el_kind) == it.kind, {it.tag, " el_kind"}, int'(el_kind), it.kind);
                    chk(dst_off == src_off, {it.tag, " R2 dst_off"}, int'(dst_off), int'(src_off));
                    el_exc      = it.exc;
                    el_cmp_zero = it.cmpz;
                end
            end else begin
                el_exc = 1'b0;
            end
        end
    end

    task automatic load_vl(input int v);
        @(negedge clk);
        vl_value = VL_W'(v);
        vl_load  = 1'b1;
        @(negedge clk);
        vl_load = 1'b0;
        cur_vl = v;
        cur_e  = 0;
        cur_s  = 0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: builds the expected stream from the requirements, then starts.
    task automatic run(input int sv, input logic [MAXVL-1:0] mask, input bit x0,
                       input bit inv, input bit zm, input bit ff, input int exc_n,
                       input logic [MAXVL-1:0] cz, input string tag);
        int vn = (cur_vl == 0) ? 1 : cur_vl;
        int sn = (cur_vl == 0) ? 1 : sv + 1;
        int e = cur_e;
        int s = cur_s;
        int n = 0;
        bit stop;
        logic b;
        exp_t it;
        @(negedge clk);
        subvl_code = 2'(sv); pred_mask = mask; pred_zero_reg = x0;
        pred_invert = inv; zero_mode = zm; ff_enable = ff;
        forever begin
            it.src = e; it.sub = s; it.done = 0; it.tag = tag;
            b = (x0 ? 1'b0 : mask[e]) ^ inv;
            it.kind = (cur_vl == 0 || b) ? 0 : (zm ? 2 : 1);
            it.exc  = (n == exc_n) && (it.kind != 1);
            it.cmpz = cz[e];
            q.push_back(it);
            n++;
            if (it.exc) begin
                cur_e = e; cur_s = s;
                break;
            end
            stop = (e == vn - 1 && s == sn - 1) ||
                   (ff && cur_vl != 0 && ((it.kind == 0 && it.cmpz) || it.kind == 2));
            if (stop) begin
                it.done = 1; it.exc = 0;
                q.push_back(it);
                cur_e = 0; cur_s = 0;
                break;
            end
            if (s == sn - 1) begin s = 0; e++; end
            else s++;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!el_valid, "R1 el_valid", int'(el_valid), 0);
        chk(!loop_done, "R1 loop_done", int'(loop_done), 0);
        chk(src_off == 0 && dst_off == 0 && sub_off == 0, "R1 offsets", int'(src_off), 0);

        // R2: plain sequence, group of one
        load_vl(5);
        run(0, '1, 0, 0, 0, 0, -1, '0, "R2 plain");
        // R2: group of four across the whole length
        load_vl(16);
        run(3, '1, 0, 0, 0, 0, -1, '0, "R2 max length group4");

        // R3 R4: one group masked, skipped, offsets still advance
        load_vl(3);
        run(2, 16'h0005, 0, 0, 0, 0, -1, '0, "R4 skip group");
        // R5: zeroing mode
        run(2, 16'h0005, 0, 0, 1, 0, -1, '0, "R5 zero group");
        // R3: invert complements the mask
        load_vl(4);
        run(1, 16'h0003, 0, 1, 0, 0, -1, '0, "R3 invert");

        // R6: exception at element 2 sub 1, then resume
        load_vl(6);
        run(1, '1, 0, 0, 0, 0, 5, '0, "R6 exception");
        chk(!el_valid && !loop_done, "R6 halted", int'(el_valid), 0);
        chk(src_off == 2, "R6 src_off held", int'(src_off), 2);
        chk(sub_off == 1, "R6 sub_off held", int'(sub_off), 1);
        run(1, '1, 0, 0, 0, 0, -1, '0, "R6 resume");

        // R8: exception, then a new length clears the offsets
        run(1, '1, 0, 0, 0, 0, 3, '0, "R8 exception");
        chk(src_off == 1 && sub_off == 1, "R8 offsets before load", int'(src_off), 1);
        load_vl(4);
        chk(src_off == 0 && dst_off == 0 && sub_off == 0, "R8 offsets cleared", int'(src_off), 0);
        run(0, '1, 0, 0, 0, 0, -1, '0, "R8 fresh run");

        // R9: fail-first stops at the first zero result
        load_vl(8);
        run(0, '1, 0, 0, 0, 1, -1, 16'h0008, "R9 ff stop");
        // R10: zeroing off, a skipped element's compare is ignored
        run(0, 16'hFFF7, 0, 0, 0, 1, -1, 16'h0028, "R10 ff skip ignored");
        // R10: zeroing on, the first masked element ends the loop
        run(1, 16'hFFFB, 0, 0, 1, 1, -1, '0, "R10 ff zero ends");

        // R11: zero register as predicate
        load_vl(3);
        run(0, '0, 1, 1, 0, 0, -1, '0, "R11 zero reg inverted");
        run(0, '1, 1, 0, 0, 0, -1, '0, "R11 zero reg plain");

        // R12: length zero issues one scalar element
        load_vl(0);
        run(3, '0, 0, 0, 1, 1, -1, '1, "R12 scalar");

        // R13: stall with ready low
        load_vl(2);
        @(negedge clk);
        el_ready = 1'b0;
        subvl_code = 2'd0; pred_mask = '1; pred_zero_reg = 0; pred_invert = 0;
        zero_mode = 0; ff_enable = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(el_valid, "R13 valid while stalled", int'(el_valid), 1);
            chk(src_off == 0 && sub_off == 0, "R13 offsets while stalled", int'(src_off), 0);
            @(negedge clk);
        end
        begin
            exp_t it;
            it.src = 0; it.sub = 0; it.kind = 0; it.done = 0; it.exc = 0; it.cmpz = 0;
            it.tag = "R13 after stall";
            q.push_back(it);
            it.src = 1;
            q.push_back(it);
            it.done = 1;
            q.push_back(it);
        end
        el_ready = 1'b1;
        drain();

        chk(q.size() == 0, "R2 leftover expected items", q.size(), 0);
        report();
    end
endmodule